// File: doc/BRIEF.md
# Remappable two-level bus address decoder

This block sits on the address path of one bus master and turns each address into a slave select. The first level uses the top four address bits to pick one of sixteen 256 MB banks. Each bank goes to the external chip selects, to the peripheral bridge or to internal memory, or it is left unused. Bank 0 then gets a second level of decode in 1 MB steps. That level reaches the internal ROM and three internal SRAM regions. An access that falls in unused space raises an abort instead of a select.

The 1 MB region at address zero is an alias, and the target depends on two pieces of state. The first is a boot-mode strap, tracked while reset is held and frozen when reset is released. The second is a sticky remap bit, set by a one-cycle command. Before remap, the region at zero points at either the ROM or external chip select 0, depending on the strap. After remap it points at the third SRAM region, which stays reachable at its own address too. A parameter turns the aliasing off, so ports of other masters can use the same module with a fixed map.

The selects and the abort are combinational from the address and the valid flag. The strap and remap registers change the map only on a clock edge.

Top module: `addr_dec_remap`

## Requirements
- R1: With valid high, an address in bank b (bits [31:28]) for b from 1 to 9 drives only select bit b+3. Bits 4..9 are the six chip selects of the first external bus, in order, and bits 10..12 are the three chip selects of the second external bus, in order.
- R2: With valid high, an address in bank 15 drives only select bit 13, the peripheral bridge.
- R3: With valid high and bank 0, the 1 MB region in bits [27:20] equal to 1, 2 or 3 drives only select bit 1, 2 or 3 (SRAM regions A, B, C).
- R4: With valid high and no remap done, the region at zero (bits [31:20] all zero) drives select bit 0 (ROM) when the captured strap is 1, and select bit 4 (external chip select 0) when it is 0.
- R5: The strap is sampled on every clock edge while the synchronous active-low reset is asserted and is held from reset release on. Later changes of the strap pin leave the map unchanged.
- R6: A remap command high at a clock edge outside reset makes the region at zero drive select bit 3 from the next cycle on. Region 3 still drives bit 3. The remap stays set across further commands and is cleared only by reset. Before that edge, the old map applies.
- R7: With valid high, banks 10 to 14, and bank 0 regions 4 to 255, drive abort high and no select.
- R8: With valid low, all selects and the abort are 0, whatever the address.
- R9: With the alias parameter off, the region at zero always drives select bit 0 (ROM), whatever the strap and remap state.
- R10: At most one select bit is high at any time, and abort is never high together with a select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_strap_i | input | 1 | Boot-mode strap, captured while in reset |
| remap_cmd_i | input | 1 | One-cycle remap command |
| addr_i | input | 32 | Master address |
| valid_i | input | 1 | Address is valid this cycle |
| slave_sel_o | output | 14 | One-hot slave select (bit map in R1 to R4) |
| abort_o | output | 1 | Access to unmapped space |

## Verification
The bench builds two instances that share their inputs. One uses the default parameters with aliasing on. The other turns aliasing off, which brings the fixed-map behaviour of other masters' ports within reach. Both use the default bank layout of six plus three external chip selects and the peripheral bridge in bank 15. Running both instances against the same strap, remap and reset sequence shows that only the region at zero differs between them. It also shows that both strap values and the sticky remap are seen across two resets.

// File: rtl/addr_dec_pkg.sv
`timescale 1ns/1ps
package addr_dec_pkg;

   // Fixed positions in the select vector ahead of the external chip selects
   localparam int SEL_ROM_BIT = 0;
   localparam int SEL_SRAM_LSB = 1;

   // What the first decode level makes of a bank
   typedef enum logic [1:0] {
      BANK_INTERNAL = 2'd0,
      BANK_EXTERNAL = 2'd1,
      BANK_PERIPH   = 2'd2,
      BANK_UNUSED   = 2'd3
   } bank_kind_e;

endpackage

// File: rtl/addr_dec_ctrl.sv
`timescale 1ns/1ps
// Boot strap capture and sticky remap bit
module addr_dec_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_strap_i,
   input  logic remap_cmd_i,
   output logic boot_q,
   output logic remap_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         boot_q  <= boot_strap_i;
         remap_q <= 1'b0;
      end else begin
         boot_q  <= boot_q;
         if (remap_cmd_i) begin
            remap_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/addr_dec_bank.sv
`timescale 1ns/1ps
// First decode level: bank number to bank kind and external one-hot
module addr_dec_bank
   import addr_dec_pkg::*;
#(
   parameter int BANK_W         = 4,
   parameter int N_EXT          = 9,
   parameter int EXT_FIRST_BANK = 1,
   parameter int INTERNAL_BANK  = 0,
   parameter int PERIPH_BANK    = 15
) (
   input  logic [BANK_W-1:0] bank_i,
   output bank_kind_e        kind_o,
   output logic [N_EXT-1:0]  ext_oh_o
);

   logic ext_hit;

   for (genvar i = 0; i < N_EXT; i++) begin : g_ext
      assign ext_oh_o[i] = (bank_i == BANK_W'(EXT_FIRST_BANK + i));
   end

   assign ext_hit = |ext_oh_o;

   always_comb begin
      if (bank_i == BANK_W'(INTERNAL_BANK)) begin
         kind_o = BANK_INTERNAL;
      end else if (bank_i == BANK_W'(PERIPH_BANK)) begin
         kind_o = BANK_PERIPH;
      end else if (ext_hit) begin
         kind_o = BANK_EXTERNAL;
      end else begin
         kind_o = BANK_UNUSED;
      end
   end

endmodule

// File: rtl/addr_dec_internal.sv
`timescale 1ns/1ps
// Second decode level inside the internal bank, with the zero-region alias
module addr_dec_internal #(
   parameter int REGION_W = 8,
   parameter int N_SRAM   = 3,
   parameter bit ALIAS_EN = 1'b1
) (
   input  logic [REGION_W-1:0] region_i,
   input  logic                boot_q,
   input  logic                remap_q,
   output logic                rom_o,
   output logic [N_SRAM-1:0]   sram_o,
   output logic                ext0_o,
   output logic                miss_o
);

   localparam int LAST_SRAM = N_SRAM - 1;

   logic              zero_hit;
   logic [N_SRAM-1:0] sram_home;
   logic              zero_rom;
   logic              zero_ext;
   logic              zero_sram;

   assign zero_hit = (region_i == '0);

   for (genvar i = 0; i < N_SRAM; i++) begin : g_sram
      assign sram_home[i] = (region_i == REGION_W'(i + 1));
   end

   if (ALIAS_EN) begin : g_alias
      assign zero_sram = zero_hit & remap_q;
      assign zero_rom  = zero_hit & ~remap_q & boot_q;
      assign zero_ext  = zero_hit & ~remap_q & ~boot_q;
   end else begin : g_fixed
      logic unused_state;
      assign unused_state = boot_q ^ remap_q;
      assign zero_sram = 1'b0;
      assign zero_rom  = zero_hit;
      assign zero_ext  = 1'b0;
   end

   always_comb begin
      sram_o = sram_home;
      sram_o[LAST_SRAM] = sram_home[LAST_SRAM] | zero_sram;
   end

   assign rom_o  = zero_rom;
   assign ext0_o = zero_ext;
   assign miss_o = ~zero_hit & ~(|sram_home);

endmodule

// File: rtl/addr_dec_remap.sv
`timescale 1ns/1ps
// Top: remappable two-level address decoder for one master port
module addr_dec_remap
   import addr_dec_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int BANK_W         = 4,
   parameter int REGION_LSB     = 20,
   parameter int N_SRAM         = 3,
   parameter int N_EXT_A        = 6,
   parameter int N_EXT_B        = 3,
   parameter int EXT_FIRST_BANK = 1,
   parameter int PERIPH_BANK    = 15,
   parameter bit ALIAS_EN       = 1'b1,
   localparam int N_EXT         = N_EXT_A + N_EXT_B,
   localparam int N_SEL         = 1 + N_SRAM + N_EXT + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_strap_i,
   input  logic              remap_cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              valid_i,
   output logic [N_SEL-1:0]  slave_sel_o,
   output logic              abort_o
);

   localparam int REGION_W   = ADDR_W - BANK_W - REGION_LSB;
   localparam int EXT_LSB    = SEL_SRAM_LSB + N_SRAM;
   localparam int PERIPH_BIT = N_SEL - 1;
   localparam int N_BANK     = 1 << BANK_W;

   // Elaboration-time parameter checks
   if (REGION_W < 2) begin : g_bad_region
      $error("addr_dec_remap: address too narrow for two decode levels");
   end
   if (EXT_FIRST_BANK < 1 || EXT_FIRST_BANK + N_EXT > PERIPH_BANK) begin : g_bad_ext
      $error("addr_dec_remap: external banks overlap internal or peripheral bank");
   end
   if (PERIPH_BANK >= N_BANK) begin : g_bad_periph
      $error("addr_dec_remap: peripheral bank outside the bank range");
   end
   if (N_SRAM < 1 || N_SRAM + 1 >= (1 << REGION_W)) begin : g_bad_sram
      $error("addr_dec_remap: SRAM region count does not fit bank 0");
   end

   logic [BANK_W-1:0]   bank;
   logic [REGION_W-1:0] region;
   logic                unused_low;
   logic                boot_q;
   logic                remap_q;
   bank_kind_e          kind;
   logic [N_EXT-1:0]    ext_oh;
   logic                int_rom;
   logic [N_SRAM-1:0]   int_sram;
   logic                int_ext0;
   logic                int_miss;
   logic                in_int;
   logic [N_SEL-1:0]    sel_raw;
   logic                abort_raw;

   assign bank       = addr_i[ADDR_W-1 -: BANK_W];
   assign region     = addr_i[REGION_LSB +: REGION_W];
   assign unused_low = ^addr_i[REGION_LSB-1:0];

   addr_dec_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .boot_strap_i (boot_strap_i),
      .remap_cmd_i  (remap_cmd_i),
      .boot_q       (boot_q),
      .remap_q      (remap_q)
   );

   addr_dec_bank #(
      .BANK_W         (BANK_W),
      .N_EXT          (N_EXT),
      .EXT_FIRST_BANK (EXT_FIRST_BANK),
      .INTERNAL_BANK  (0),
      .PERIPH_BANK    (PERIPH_BANK)
   ) u_bank (
      .bank_i   (bank),
      .kind_o   (kind),
      .ext_oh_o (ext_oh)
   );

   addr_dec_internal #(
      .REGION_W (REGION_W),
      .N_SRAM   (N_SRAM),
      .ALIAS_EN (ALIAS_EN)
   ) u_int (
      .region_i (region),
      .boot_q   (boot_q),
      .remap_q  (remap_q),
      .rom_o    (int_rom),
      .sram_o   (int_sram),
      .ext0_o   (int_ext0),
      .miss_o   (int_miss)
   );

   assign in_int = (kind == BANK_INTERNAL);

   always_comb begin
      sel_raw = '0;
      sel_raw[SEL_ROM_BIT] = in_int & int_rom;
      sel_raw[SEL_SRAM_LSB +: N_SRAM] = in_int ? int_sram : '0;
      sel_raw[EXT_LSB +: N_EXT] = ext_oh;
      sel_raw[EXT_LSB] = ext_oh[0] | (in_int & int_ext0);
      sel_raw[PERIPH_BIT] = (kind == BANK_PERIPH);
      abort_raw = (kind == BANK_UNUSED) | (in_int & int_miss);
   end

   assign slave_sel_o = valid_i ? sel_raw : '0;
   assign abort_o     = valid_i & abort_raw;

endmodule

// File: rtl/addr_dec_remap_chk.sv
`timescale 1ns/1ps
// Port-level checker for addr_dec_remap
module addr_dec_remap_chk #(
   parameter int ADDR_W         = 32,
   parameter int BANK_W         = 4,
   parameter int REGION_LSB     = 20,
   parameter int N_SRAM         = 3,
   parameter int N_EXT          = 9,
   parameter int EXT_FIRST_BANK = 1,
   parameter int PERIPH_BANK    = 15,
   parameter bit ALIAS_EN       = 1'b1,
   parameter int N_SEL          = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              remap_cmd_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              valid_i,
   input logic [N_SEL-1:0]  slave_sel_o,
   input logic              abort_o
);

   localparam int EXT_LSB    = 1 + N_SRAM;
   localparam int PERIPH_BIT = N_SEL - 1;
   localparam int C_BIT      = N_SRAM;
   localparam int LAST_EXT   = EXT_FIRST_BANK + N_EXT - 1;

   logic [BANK_W-1:0] bank;
   logic              zero_region;
   int                ext_idx;

   assign bank        = addr_i[ADDR_W-1 -: BANK_W];
   assign zero_region = (addr_i[ADDR_W-1:REGION_LSB] == '0);
   assign ext_idx     = EXT_LSB + int'(bank) - EXT_FIRST_BANK;

   assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slave_sel_o) && !(abort_o && (slave_sel_o != '0)));

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |-> (slave_sel_o == '0) && !abort_o);

   assert_periph_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && bank == BANK_W'(PERIPH_BANK)) |-> slave_sel_o[PERIPH_BIT]);

   assert_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && int'(bank) >= EXT_FIRST_BANK && int'(bank) <= LAST_EXT)
      |-> slave_sel_o[ext_idx]);

   assert_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && int'(bank) > LAST_EXT && int'(bank) < PERIPH_BANK) |-> abort_o);

   assert_remap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ALIAS_EN && remap_cmd_i) |=> (!(valid_i && zero_region) || slave_sel_o[C_BIT]));

   assert_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ALIAS_EN && valid_i && zero_region) |-> slave_sel_o[0]);

endmodule

bind addr_dec_remap addr_dec_remap_chk #(
   .ADDR_W         (ADDR_W),
   .BANK_W         (BANK_W),
   .REGION_LSB     (REGION_LSB),
   .N_SRAM         (N_SRAM),
   .N_EXT          (N_EXT),
   .EXT_FIRST_BANK (EXT_FIRST_BANK),
   .PERIPH_BANK    (PERIPH_BANK),
   .ALIAS_EN       (ALIAS_EN),
   .N_SEL          (N_SEL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .remap_cmd_i (remap_cmd_i),
   .addr_i      (addr_i),
   .valid_i     (valid_i),
   .slave_sel_o (slave_sel_o),
   .abort_o     (abort_o)
);

// File: tb/tb_addr_dec_remap.sv
`timescale 1ns/1ps
module tb_addr_dec_remap;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_strap = 1'b1;
   logic        remap_cmd = 1'b0;
   logic [31:0] addr = '0;
   logic        valid = 1'b0;
   logic [13:0] sel_a;
   logic        abort_a;
   logic [13:0] sel_n;
   logic        abort_n;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // Bench model state
   bit m_strap = 1'b1;
   bit m_remap = 1'b0;

   always #2.5 clk = ~clk;

   addr_dec_remap dut (
      .clk (clk), .rst_n (rst_n), .boot_strap_i (boot_strap),
      .remap_cmd_i (remap_cmd), .addr_i (addr), .valid_i (valid),
      .slave_sel_o (sel_a), .abort_o (abort_a)
   );

   addr_dec_remap #(.ALIAS_EN(1'b0)) dut_na (
      .clk (clk), .rst_n (rst_n), .boot_strap_i (boot_strap),
      .remap_cmd_i (remap_cmd), .addr_i (addr), .valid_i (valid),
      .slave_sel_o (sel_n), .abort_o (abort_n)
   );

   // Expected {abort, selects} from the requirements
   function automatic logic [14:0] model(input logic [31:0] a, input logic v,
                                         input bit strap, input bit remap, input bit alias_on);
      logic [13:0] s;
      logic        ab;
      int          bk;
      int          rg;
      s  = '0;
      ab = 1'b0;
      bk = int'(a[31:28]);
      rg = int'(a[27:20]);
      if (v) begin
         if (bk >= 1 && bk <= 9) s[bk + 3] = 1'b1;
         else if (bk == 15) s[13] = 1'b1;
         else if (bk == 0) begin
            if (rg >= 1 && rg <= 3) s[rg] = 1'b1;
            else if (rg == 0) begin
               if (alias_on && remap) s[3] = 1'b1;
               else if (alias_on && !strap) s[4] = 1'b1;
               else s[0] = 1'b1;
            end else ab = 1'b1;
         end else ab = 1'b1;
      end
      return {ab, s};
   endfunction

   task automatic compare(input string tag, input string who, input logic [14:0] act,
                          input logic [14:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s addr=%h actual=%b expected=%b", tag, who, addr, act, exp);
      end
   endtask

   // Drive one access away from the edge and check both instances
   task automatic access(input logic [31:0] a, input logic v, input string tag);
      @(negedge clk);
      addr  = a;
      valid = v;
      #1;
      compare(tag, "alias", {abort_a, sel_a}, model(a, v, m_strap, m_remap, 1'b1));
      compare(tag, "fixed", {abort_n, sel_n}, model(a, v, m_strap, m_remap, 1'b0));
      n_checks++;
      if ($countones({abort_a, sel_a}) > 1) begin
         n_fails++;
         $display("FAIL R10 alias actual=%b expected=at most one bit", {abort_a, sel_a});
      end
   endtask

   task automatic do_reset(input bit strap);
      @(negedge clk);
      rst_n      = 1'b0;
      boot_strap = strap;
      repeat (3) @(negedge clk);
      rst_n   = 1'b1;
      m_strap = strap;
      m_remap = 1'b0;
   endtask

   task automatic test_reset_state();
      access(32'hF000_0000, 1'b0, "R8_reset");
      access(32'h0000_0000, 1'b1, "R4_strap1");
   endtask

   task automatic test_strap_hold();
      @(negedge clk);
      boot_strap = 1'b0;
      repeat (2) @(negedge clk);
      access(32'h0001_2340, 1'b1, "R5_hold");
      boot_strap = 1'b1;
   endtask

   task automatic test_banks();
      for (int b = 1; b <= 9; b++) access({b[3:0], 28'h0AB_CDE0}, 1'b1, "R1_ext");
      access(32'hF123_4567, 1'b1, "R2_periph");
      access(32'hFFFF_FFFF, 1'b1, "R2_periph_top");
      for (int b = 10; b <= 14; b++) access({b[3:0], 28'h000_0004}, 1'b1, "R7_bank");
   endtask

   task automatic test_internal();
      access(32'h0010_0000, 1'b1, "R3_sram_a");
      access(32'h002F_FFFC, 1'b1, "R3_sram_b");
      access(32'h0030_0800, 1'b1, "R3_sram_c");
      access(32'h0040_0000, 1'b1, "R7_region4");
      access(32'h0FF0_0000, 1'b1, "R7_region255");
   endtask

   task automatic test_idle();
      access(32'h1000_0000, 1'b0, "R8_ext");
      access(32'hC000_0000, 1'b0, "R8_unused");
      access(32'h0000_0010, 1'b0, "R8_zero");
   endtask

   task automatic test_remap();
      @(negedge clk);
      remap_cmd = 1'b1;
      addr      = 32'h0000_0100;
      valid     = 1'b1;
      #1;
      compare("R6_before", "alias", {abort_a, sel_a}, model(addr, 1'b1, m_strap, 1'b0, 1'b1));
      @(negedge clk);
      remap_cmd = 1'b0;
      m_remap   = 1'b1;
      access(32'h0000_0100, 1'b1, "R6_after");
      access(32'h0030_0000, 1'b1, "R6_home");
      access(32'h0000_0000, 1'b1, "R9_fixed_remap");
      @(negedge clk);
      remap_cmd = 1'b1;
      @(negedge clk);
      remap_cmd = 1'b0;
      repeat (3) @(negedge clk);
      access(32'h000F_FFFF, 1'b1, "R6_sticky");
   endtask

   task automatic test_strap0();
      do_reset(1'b0);
      access(32'h0000_0000, 1'b1, "R4_strap0");
      access(32'h0000_0000, 1'b1, "R9_strap0");
      access(32'h1000_0000, 1'b1, "R1_cs0");
      access(32'h0030_0000, 1'b1, "R6_cleared");
   endtask

   initial begin
      do_reset(1'b1);
      test_reset_state();
      test_strap_hold();
      test_banks();
      test_internal();
      test_idle();
      test_remap();
      test_strap0();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule